// File: doc/BRIEF.md
# Multichannel ADC Sample Sequencer

This block drives a successive-approximation converter through a list of channels that software programs. On a start command it walks the list from the first entry. For each entry it raises a conversion request toward an abstract converter and holds the channel number steady until the converter answers with a done pulse and a sample. Each result is tagged with its channel number and pushed into a result FIFO. Between two consecutive conversions the block waits for a programmable gap. The gap is an 8-bit count plus one, multiplied by a unit of 1, 4, 16 or 64 clock cycles.

Software works through a small register interface. It has a control word (enable, continuous, start, stop), a channel-list word, a gap word, a status word and a FIFO read port. The status word reports three busy bits, which say whether a request is outstanding, a gap is running or a pass is active. It also reports full and empty flags, a sticky overflow flag and the live FIFO occupancy. Register reads are combinational, so `bus_rdata` follows `bus_addr` in the same cycle. A FIFO entry is popped at the clock edge that samples `bus_rd`.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `conv_req` is low. The status word (address 3) reads 0x10: empty (bit 4) is set, and busy (bits 2:0), full (bit 3), overflow (bit 5) and count (bits 11:6) are all zero.
- R2: A control write (address 0) with start (bit 2) and enable (bit 0) set and stop (bit 3) clear starts a pass. The pass-active busy bit (status bit 2) reads 1 in the first cycle after that write. A start written with enable clear is ignored, and no request follows.
- R3: Entries are converted in list order from entry 0. `conv_chan` presents entry n, taken from list-word bits [3n+2:3n]. The last entry used is set by the max-index field, list-word bits [26:24], so a value of 0 means one entry.
- R4: With continuous mode (control bit 1) off, a pass produces exactly one conversion per active entry. After that all busy bits clear.
- R5: With continuous mode on, the list wraps from the last entry back to entry 0, and conversions continue without end.
- R6: A FIFO word (address 4) holds the channel in bits [14:12] and the sample in bits [11:0]. Bits [31:15] are zero.
- R7: After a done pulse that is followed by another conversion, `conv_req` stays low for (count+1)·4^sel cycles. Here count is gap-word bits [7:0] and sel is bits [9:8].
- R8: A read of address 4 while the FIFO holds data returns the oldest word and lowers the count by one. A read while the FIFO is empty returns the last word popped and leaves the count unchanged.
- R9: A result that arrives while the FIFO is full is dropped, even when a pop happens in the same cycle, and the overflow flag is set. The flag stays set until the next accepted start.
- R10: A stop (control bit 3), or a control write with enable clear, ends the run. A conversion already in flight completes and its result is stored. No further request is issued, and all busy bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at address 4) |
| bus_addr | input | 3 | Register address: 0 control, 1 list, 2 gap, 3 status, 4 FIFO |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| conv_req | output | 1 | Conversion request, held until done |
| conv_chan | output | 3 | Channel of the current request |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_data | input | DATA_W | Sample that comes with `conv_done` |

## Verification
Two functions can fall in one cycle: a conversion result arriving while the FIFO is full, and a software pop of that same FIFO. The bench lets a continuous run over all eight channels fill the FIFO and keep converting, then issues back-to-back FIFO reads. Some done pulses therefore land on the very edge that also pops a word. A queue model in the bench decides drop or accept from its occupancy before the pop and compares count, full, empty and overflow on every cycle, so a design that lets the pop free a slot for the incoming word diverges at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;

   localparam int CHAN_W = 3;
   localparam int VAL_W  = 12;
   localparam int WORD_W = CHAN_W + VAL_W;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_LIST = 3'd1;
   localparam logic [2:0] A_GAP  = 3'd2;
   localparam logic [2:0] A_STAT = 3'd3;
   localparam logic [2:0] A_FIFO = 3'd4;

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
   parameter int W     = 15,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("adc_seq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt_q;
   logic          wr_ok, rd_ok;

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign wr_ok = push & ~full;
   assign rd_ok = pop & ~empty;
   assign head  = mem[rd_ptr];
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> $stable(count));
   p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

endmodule

// File: rtl/adc_seq_gap_timer.sv
module adc_seq_gap_timer #(
   parameter int GW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [GW-1:0] load_val,
   output logic          zero
);

   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   p_load_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
   import adc_seq_pkg::*;
#(
   parameter int NCH = 8,
   parameter int GW  = 15,
   localparam int IW = $clog2(NCH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic                  halt,
   input  logic                  cont,
   input  logic [NCH*CHAN_W-1:0] list,
   input  logic [IW-1:0]         max_idx,
   input  logic [GW-1:0]         gap_total,
   input  logic                  conv_done,
   output logic                  conv_req,
   output logic [CHAN_W-1:0]     conv_chan,
   output logic                  res_valid,
   output logic                  gap_busy,
   output logic                  seq_busy
);

   seq_state_e        state;
   logic [IW-1:0]     idx;
   logic              stop_pend;
   logic              last, carry_on, tmr_zero;
   logic [CHAN_W-1:0] entry [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_entry
      assign entry[g] = list[g*CHAN_W +: CHAN_W];
   end

   assign last      = (idx == max_idx);
   assign conv_req  = (state == ST_CONV);
   assign gap_busy  = (state == ST_GAP);
   assign seq_busy  = (state != ST_IDLE);
   assign conv_chan = entry[idx];
   assign res_valid = conv_req & conv_done;
   assign carry_on  = res_valid & ~go & ~halt & ~stop_pend & ~(last & ~cont);

   adc_seq_gap_timer #(.GW(GW)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (carry_on),
      .load_val (gap_total - 1'b1),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         stop_pend <= 1'b0;
      end else if (go) begin
         state     <= ST_CONV;
         idx       <= '0;
         stop_pend <= 1'b0;
      end else begin
         case (state)
            ST_CONV: begin
               if (conv_done) begin
                  if (carry_on) begin
                     state <= ST_GAP;
                     idx   <= last ? '0 : idx + 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else if (halt) begin
                  stop_pend <= 1'b1;
               end
            end
            ST_GAP: begin
               if (halt || stop_pend) state <= ST_IDLE;
               else if (tmr_zero)     state <= ST_CONV;
            end
            default: begin
               state     <= ST_IDLE;
               stop_pend <= 1'b0;
            end
         endcase
      end
   end

   p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (seq_busy && conv_req));
   p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done && !go) |=> $stable(conv_chan));
   p_gap_to_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_busy && tmr_zero && !halt && !stop_pend && !go) |=> conv_req);
   p_halt_in_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_busy && halt && !go) |=> !seq_busy);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int DEPTH     = 32,
   parameter int DATA_W    = 12,
   parameter int CNT_BITS  = 8,
   parameter int UNIT_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              conv_req,
   output logic [2:0]        conv_chan,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data
);

   localparam int IW     = $clog2(NCH);
   localparam int LW     = NCH * CHAN_W;
   localparam int GW     = CNT_BITS + 1 + 3 * UNIT_LOG2;
   localparam int CW     = $clog2(DEPTH) + 1;

   if ((1 << IW) != NCH || LW + IW > 32) begin : g_bad_nch
      $error("adc_seq_ctrl: NCH must be a power of two fitting the list word");
   end
   if (DATA_W > VAL_W || DATA_W < 1) begin : g_bad_data
      $error("adc_seq_ctrl: DATA_W must lie in 1..12");
   end
   if (6 + CW > 32 || CNT_BITS + 2 > 32) begin : g_bad_fields
      $error("adc_seq_ctrl: status or gap fields exceed the word");
   end

   logic              en_q, cont_q, ovf_q;
   logic [LW-1:0]     list_q;
   logic [IW-1:0]     maxi_q;
   logic [CNT_BITS-1:0] gcnt_q;
   logic [1:0]        gsel_q;
   logic [WORD_W-1:0] last_rd_q, head, push_word;
   logic [VAL_W-1:0]  val_ext;
   logic [CW-1:0]     fcount;
   logic              full, empty, res_valid, gap_busy, seq_busy;
   logic              wr_ctrl, go, halt, pop, drop;
   logic [GW-1:0]     gap_base, gap_total;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign go      = wr_ctrl & bus_wdata[2] & bus_wdata[0] & ~bus_wdata[3];
   assign halt    = wr_ctrl & ~go & (bus_wdata[3] | ~bus_wdata[0]);
   assign pop     = bus_rd && (bus_addr == A_FIFO);
   assign drop    = res_valid & full;

   assign gap_base  = GW'(gcnt_q) + GW'(1);
   assign gap_total = gap_base << (UNIT_LOG2 * int'(gsel_q));

   if (DATA_W == VAL_W) begin : g_val_full
      assign val_ext = conv_data;
   end else begin : g_val_pad
      assign val_ext = {{(VAL_W-DATA_W){1'b0}}, conv_data};
   end
   assign push_word = {conv_chan, val_ext};

   adc_seq_engine #(.NCH(NCH), .GW(GW)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .halt      (halt),
      .cont      (cont_q),
      .list      (list_q),
      .max_idx   (maxi_q),
      .gap_total (gap_total),
      .conv_done (conv_done),
      .conv_req  (conv_req),
      .conv_chan (conv_chan),
      .res_valid (res_valid),
      .gap_busy  (gap_busy),
      .seq_busy  (seq_busy)
   );

   adc_seq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (res_valid),
      .push_data (push_word),
      .pop       (pop),
      .head      (head),
      .count     (fcount),
      .full      (full),
      .empty     (empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         cont_q    <= 1'b0;
         list_q    <= '0;
         maxi_q    <= '0;
         gcnt_q    <= '0;
         gsel_q    <= '0;
         ovf_q     <= 1'b0;
         last_rd_q <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q   <= bus_wdata[0];
            cont_q <= bus_wdata[1];
         end
         if (bus_wr && bus_addr == A_LIST) begin
            list_q <= bus_wdata[LW-1:0];
            maxi_q <= bus_wdata[LW +: IW];
         end
         if (bus_wr && bus_addr == A_GAP) begin
            gcnt_q <= bus_wdata[CNT_BITS-1:0];
            gsel_q <= bus_wdata[CNT_BITS +: 2];
         end
         if (go)        ovf_q <= 1'b0;
         else if (drop) ovf_q <= 1'b1;
         if (pop && !empty) last_rd_q <= head;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: bus_rdata[1:0] = {cont_q, en_q};
         A_LIST: begin
            bus_rdata[LW-1:0]  = list_q;
            bus_rdata[LW +: IW] = maxi_q;
         end
         A_GAP: begin
            bus_rdata[CNT_BITS-1:0]  = gcnt_q;
            bus_rdata[CNT_BITS +: 2] = gsel_q;
         end
         A_STAT: begin
            bus_rdata[5:0]     = {ovf_q, empty, full, seq_busy, gap_busy, conv_req};
            bus_rdata[6 +: CW] = fcount;
         end
         A_FIFO:  bus_rdata[WORD_W-1:0] = empty ? last_rd_q : head;
         default: bus_rdata = '0;
      endcase
   end

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !go) |=> ovf_q);
   p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !ovf_q);
   p_drop_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !go) |=> ovf_q);

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

   localparam int DEPTH = 32;
   localparam int LAT   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd3;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        conv_req;
   logic [2:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [11:0] conv_data = '0;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
      .conv_data(conv_data)
   );

   always #4 clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   // reference state
   logic [14:0] q[$];
   logic [14:0] m_last = '0;
   bit          m_ovf = 0;
   int          m_idx = 0;
   int          m_max = 0;
   logic [2:0]  m_list [8];
   int          exp_gap = 1;
   int          n_done = 0;
   int          seed = 1;
   logic [2:0]  resp_chan = '0;
   int          hi_cnt = 0, low_run = 0;
   bit          in_gap = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // converter responder and per-conversion checks (R3, R5, R7)
   always @(negedge clk) begin
      if (rst_n) begin
         if (conv_done) begin
            conv_done = 1'b0;
            low_run   = conv_req ? 0 : 1;
            in_gap    = 1;
         end else if (conv_req) begin
            if (in_gap) begin
               check(low_run == exp_gap, "R7 gap length", low_run, exp_gap);
               in_gap = 0;
            end
            hi_cnt++;
            if (hi_cnt == LAT) begin
               check(conv_chan == m_list[m_idx], "R3/R5 channel order", conv_chan, m_list[m_idx]);
               m_idx     = (m_idx == m_max) ? 0 : m_idx + 1;
               resp_chan = conv_chan;
               seed      = seed + 1;
               conv_data = 12'((seed * 37 + int'(conv_chan) * 5) & 12'hFFF);
               conv_done = 1'b1;
               hi_cnt    = 0;
               n_done++;
            end
         end else if (in_gap) begin
            low_run++;
         end
      end
   end

   // queue model, advanced on the edge that the design also sees
   always @(posedge clk) begin
      if (rst_n) begin
         int pre;
         pre = q.size();
         if (bus_rd && bus_addr == 3'd4 && pre > 0) m_last = q.pop_front();
         if (conv_done) begin
            if (pre < DEPTH) q.push_back({resp_chan, conv_data});
            else m_ovf = 1;
         end
         if (bus_wr && bus_addr == 3'd0 && bus_wdata[2] && bus_wdata[0] && !bus_wdata[3])
            m_ovf = 0;
      end
   end

   // per-cycle status comparison (R8, R9)
   always @(negedge clk) begin
      #2;
      if (rst_n && !finished && !bus_wr && bus_addr == 3'd3) begin
         check(int'(bus_rdata[11:6]) == q.size(), "R8 count", bus_rdata[11:6], q.size());
         check(bus_rdata[3] == (q.size() == DEPTH), "R9 full", bus_rdata[3], q.size() == DEPTH);
         check(bus_rdata[4] == (q.size() == 0), "R8 empty", bus_rdata[4], q.size() == 0);
         check(bus_rdata[5] == m_ovf, "R9 overflow", bus_rdata[5], m_ovf);
      end
   end

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == 3'd0 && d[2] && d[0] && !d[3]) begin
         m_idx = 0; in_gap = 0; hi_cnt = 0;
      end
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 3'd3; bus_wdata = '0;
   endtask

   task automatic fifo_read(input string req);
      logic [14:0] exp;
      @(negedge clk);
      bus_addr = 3'd4;
      #1;
      exp = (q.size() > 0) ? q[0] : m_last;
      check(bus_rdata == {17'd0, exp}, req, bus_rdata, exp);
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = 3'd3;
   endtask

   task automatic set_list(input int maxi, input logic [2:0] c0, input logic [2:0] c1,
                           input logic [2:0] c2, input logic [2:0] c3);
      logic [31:0] w;
      m_list[0] = c0; m_list[1] = c1; m_list[2] = c2; m_list[3] = c3;
      for (int i = 4; i < 8; i++) m_list[i] = 3'(i);
      w = '0;
      for (int i = 0; i < 8; i++) w[i*3 +: 3] = m_list[i];
      w[26:24] = 3'(maxi);
      m_max = maxi;
      bus_write(3'd1, w);
   endtask

   task automatic set_gap(input int cnt, input int sel);
      exp_gap = (cnt + 1) << (2 * sel);
      bus_write(3'd2, {22'd0, 2'(sel), 8'(cnt)});
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      do begin
         @(negedge clk); #1; n++;
      end while (bus_rdata[2] && n < 3000);
      check(bus_rdata[2:0] == 3'b000, req, bus_rdata[2:0], 0);
   endtask

   task automatic quiet(input int cycles, input string req);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk); #1;
         if (conv_req) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   task automatic drain();
      for (int i = 0; i < 40 && q.size() > 0; i++) fifo_read("R8 pop order");
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 190000);
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(bus_rdata == 32'h10, "R1 reset status", bus_rdata, 32'h10);
      check(conv_req == 1'b0, "R1 reset request", conv_req, 0);

      // R2: start without enable is ignored
      base = n_done;
      bus_write(3'd0, 32'h4);
      quiet(20, "R2 start ignored when disabled");
      check(bus_rdata[2:0] == 0, "R2 idle after ignored start", bus_rdata[2:0], 0);

      // R3/R4/R6/R7: one pass of four entries
      set_gap(2, 0);
      set_list(3, 3'd5, 3'd2, 3'd7, 3'd0);
      base = n_done;
      bus_write(3'd0, 32'h5);
      #1;
      check(bus_rdata[2] == 1'b1, "R2 busy right after start", bus_rdata[2], 1);
      wait_idle("R4 idle after one pass");
      check(n_done - base == 4, "R4 one result per entry", n_done - base, 4);
      @(negedge clk); bus_addr = 3'd4; #1;
      check(bus_rdata[31:15] == 0 && bus_rdata[14:12] == 3'd5, "R6 word format", bus_rdata, 32'h5000);
      bus_addr = 3'd3;
      drain();
      fifo_read("R8 empty read returns last word");
      fifo_read("R8 empty read repeated");

      // R7 with a larger unit, R10 stop while continuous
      set_gap(1, 2);
      set_list(0, 3'd6, 3'd0, 3'd0, 3'd0);
      base = n_done;
      bus_write(3'd0, 32'h7);
      while (n_done - base < 3) @(negedge clk);
      bus_write(3'd0, 32'hB);
      wait_idle("R10 idle after stop");
      quiet(80, "R10 no request after stop");
      drain();

      // R5/R9: continuous over all entries, fill, overflow, concurrent pops
      set_gap(0, 0);
      for (int i = 0; i < 8; i++) m_list[i] = 3'(7 - i);
      begin
         logic [31:0] w = '0;
         for (int i = 0; i < 8; i++) w[i*3 +: 3] = m_list[i];
         w[26:24] = 3'd7; m_max = 7;
         bus_write(3'd1, w);
      end
      base = n_done;
      bus_write(3'd0, 32'h7);
      while (n_done - base < 40) @(negedge clk);
      @(negedge clk); #3;
      check(bus_rdata[5] == 1'b1, "R9 overflow after fill", bus_rdata[5], 1);
      for (int i = 0; i < 12; i++) fifo_read("R9 pop while full");
      bus_write(3'd0, 32'h9);
      wait_idle("R10 idle after stop in continuous");
      @(negedge clk); #3;
      check(bus_rdata[5] == 1'b1, "R9 overflow sticky", bus_rdata[5], 1);
      set_list(0, 3'd1, 3'd0, 3'd0, 3'd0);
      bus_write(3'd0, 32'h5);
      #3;
      check(bus_rdata[5] == 1'b0, "R9 overflow cleared by start", bus_rdata[5], 0);
      wait_idle("R4 single entry pass");
      drain();

      // R10: clearing enable ends a continuous run
      set_list(1, 3'd3, 3'd4, 3'd0, 3'd0);
      base = n_done;
      bus_write(3'd0, 32'h7);
      while (n_done - base < 2) @(negedge clk);
      bus_write(3'd0, 32'h0);
      wait_idle("R10 idle after enable cleared");
      quiet(30, "R10 no request after disable");
      drain();

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule